// File: doc/BRIEF.md
# Burst Write Master with Disconnect Resume

This block is the initiator side of a 32-bit multiplexed address/data bus, specialised for write bursts. It takes DMA write requests one at a time from an upstream queue through a valid/ready handshake. Each request carries a start byte address and a word count from 1 to 16. For each request the block drives one address phase. It then streams one data word per clock, pulled from a show-ahead local data port, for as long as the target signals ready.

Requests queued behind the current one are started back to back: the next address phase follows the final data phase of the previous burst with no idle clock, provided the grant input is still high. If the target asks to stop part way through a burst, the block keeps the address of the next untransferred word and the number of words left. It idles the bus for exactly two clocks and then opens a new address phase from that point. If the grant is gone at a burst boundary, the block parks idle and leaves the next request waiting upstream.

All bus control outputs are active low. One output enables the address/data and command drivers.

Top module: `burst_dma_wr`

## Requirements
- R1: An address phase lasts one clock. In it `cyc_n` is 0, `mst_rdy_n` is 1, `ad_oe` is 1, `bus_ad` carries the current word address and `bus_cmd_n` carries 4'b0111. The next clock is a data phase.
- R2: In a data phase `mst_rdy_n` is 0, `bus_ad` equals `dat_in` and `bus_cmd_n` is 4'b0000 (all four bytes enabled). A word moves on every clock where `mst_rdy_n` and `tgt_rdy_n` are both 0, so one word moves per clock while the target keeps `tgt_rdy_n` low.
- R3: `req_len` holds the word count minus one (0 to 15 gives 1 to 16 words). The address of each next word is the previous one plus 4.
- R4: In a data phase `cyc_n` is 1 exactly when the word being offered is the last one of the request, and 0 otherwise.
- R5: `dat_pop` is 1 exactly on the clocks where a word moves, so no data word is skipped or repeated, including across a disconnect.
- R6: `done` is 1 for one clock, in the clock where the final word of a request moves.
- R7: If `gnt` and `req_valid` are 1 in the clock where a final word moves, `req_ready` is 1 in that clock. The next clock is the address phase of the new request.
- R8: A disconnect is `tgt_stop_n` and `tgt_claim_n` both 0 in a data phase that does not move the final word. The block then spends two clocks with `cyc_n` and `mst_rdy_n` at 1 and `ad_oe` at 0. It then gives an address phase at the next untransferred address and finishes the remaining words.
- R9: No address phase starts unless `gnt` was 1 in the clock before it. `req_ready` is 0 while `gnt` is 0. If `gnt` is 0 when a burst ends, the block goes idle and takes no further request until `gnt` returns.
- R10: During and after reset, with no request running, `cyc_n` and `mst_rdy_n` are 1 and `ad_oe`, `dat_pop` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gnt | input | 1 | Bus grant from the arbiter |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Request accepted this clock |
| req_addr | input | 32 | Start byte address of the request |
| req_len | input | 4 | Word count minus one |
| dat_in | input | 32 | Head word of the local data queue |
| dat_pop | output | 1 | Head word consumed this clock |
| done | output | 1 | Final word of the request moved |
| cyc_n | output | 1 | Cycle active, high in the last data phase |
| mst_rdy_n | output | 1 | Initiator ready (data phase) |
| tgt_rdy_n | input | 1 | Target ready |
| tgt_claim_n | input | 1 | Target has claimed the cycle |
| tgt_stop_n | input | 1 | Target requests a stop |
| ad_oe | output | 1 | Output enable for address/data and command |
| bus_ad | output | 32 | Address or data value |
| bus_cmd_n | output | 4 | Command in address phase, byte enables in data phase |

## Verification
The bench builds the block with its default parameters: 32-bit words, 4-bit length field and a two-clock resume gap. With these values a single request covers the full 16-word burst, so one bench can drive the longest burst, one-word bursts and chains of mixed lengths. The two-clock gap can be measured directly between the stop clock and the resumed address phase. The bench stops the target both with and without a word accepted, and withdraws the grant both before any request and in the middle of a burst.

// File: rtl/burst_dma_wr.sv
module burst_dma_wr #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 4,
  parameter int GAP   = 2,
  parameter logic [DW/8-1:0] CMD_WR = 4'b0111
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gnt,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [DW-1:0]   dat_in,
  output logic            dat_pop,
  output logic            done,
  output logic            cyc_n,
  output logic            mst_rdy_n,
  input  logic            tgt_rdy_n,
  input  logic            tgt_claim_n,
  input  logic            tgt_stop_n,
  output logic            ad_oe,
  output logic [AW-1:0]   bus_ad,
  output logic [DW/8-1:0] bus_cmd_n
);
  localparam int CNT_W = LEN_W + 1;
  localparam int GAP_W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_GAP} st_t;

  st_t              st;
  logic [AW-1:0]    addr;
  logic [CNT_W-1:0] left;
  logic [GAP_W-1:0] gap_cnt;

  logic in_addr, in_data, last, xfer, fin, disc, take;

  assign in_addr = (st == S_ADDR);
  assign in_data = (st == S_DATA);
  assign last    = (left == CNT_W'(1));
  assign xfer    = in_data && !tgt_rdy_n;
  assign fin     = xfer && last;
  assign disc    = in_data && !tgt_stop_n && !tgt_claim_n && !fin;

  assign req_ready = gnt && ((st == S_IDLE) || fin);
  assign take      = req_valid && req_ready;

  assign cyc_n     = !(in_addr || (in_data && !last));
  assign mst_rdy_n = !in_data;
  assign ad_oe     = in_addr || in_data;
  assign bus_ad    = in_addr ? addr : (in_data ? AW'(dat_in) : '0);
  assign bus_cmd_n = in_addr ? CMD_WR : '0;
  assign dat_pop   = xfer;
  assign done      = fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr    <= '0;
      left    <= '0;
      gap_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (take) begin
            addr <= req_addr;
            left <= CNT_W'(req_len) + CNT_W'(1);
            st   <= S_ADDR;
          end
        end
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          if (xfer) begin
            addr <= addr + STEP;
            left <= left - CNT_W'(1);
          end
          if (fin) begin
            if (take) begin
              addr <= req_addr;
              left <= CNT_W'(req_len) + CNT_W'(1);
              st   <= S_ADDR;
            end else begin
              st <= S_IDLE;
            end
          end else if (disc) begin
            gap_cnt <= GAP_W'(GAP - 1);
            st      <= S_GAP;
          end
        end
        default: begin
          if (gap_cnt != '0)
            gap_cnt <= gap_cnt - GAP_W'(1);
          else if (gnt)
            st <= S_ADDR;
        end
      endcase
    end
  end
endmodule

// File: rtl/burst_dma_wr_chk.sv
module burst_dma_wr_chk (
  input logic clk,
  input logic rst_n,
  input logic gnt,
  input logic cyc_n,
  input logic mst_rdy_n,
  input logic tgt_rdy_n,
  input logic tgt_claim_n,
  input logic tgt_stop_n,
  input logic ad_oe,
  input logic dat_pop,
  input logic done
);
  p_addr_then_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_n && mst_rdy_n) |=> !mst_rdy_n);

  p_pop_only_on_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_pop |-> (!mst_rdy_n && !tgt_rdy_n));

  p_move_pops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_rdy_n && !tgt_rdy_n) |-> dat_pop);

  p_done_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dat_pop && cyc_n));

  // two idle clocks for the default resume gap
  p_resume_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_rdy_n && !tgt_claim_n && !tgt_stop_n && !done)
      |=> (cyc_n && mst_rdy_n && !ad_oe) ##1 (cyc_n && mst_rdy_n && !ad_oe));

  p_start_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cyc_n) |-> $past(gnt));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_n && mst_rdy_n) |-> (!ad_oe && !dat_pop && !done));
endmodule

bind burst_dma_wr burst_dma_wr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .cyc_n(cyc_n), .mst_rdy_n(mst_rdy_n),
  .tgt_rdy_n(tgt_rdy_n), .tgt_claim_n(tgt_claim_n), .tgt_stop_n(tgt_stop_n),
  .ad_oe(ad_oe), .dat_pop(dat_pop), .done(done)
);

// File: tb/burst_dma_wr_bench.sv
module burst_dma_wr_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gnt = 1'b0;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [3:0]  req_len;
  logic [31:0] dat_in;
  logic        dat_pop, done, cyc_n, mst_rdy_n, ad_oe;
  logic        tgt_rdy_n = 1'b1, tgt_claim_n = 1'b1, tgt_stop_n = 1'b1;
  logic [31:0] bus_ad;
  logic [3:0]  bus_cmd_n;

  int checks = 0, fails = 0, cyc_count = 0;

  logic [31:0] qa [16];
  logic [3:0]  ql [16];
  logic [4:0]  n_q = 0, issue_idx = 0, head = 0;
  bit          hs_pend = 0, exp_loaded = 0;
  logic [31:0] exp_addr = 0, exp_data = 32'hA000_0000, src;
  int          exp_left = 0, nap = 0, nxfer = 0, idle_run = 0;
  int          gap_log [32];
  bit          stall_mode = 0, stall_tog = 0, disc_armed = 0, disc_data = 0;
  int          disc_at = 0;

  assign req_valid = (issue_idx < n_q);
  assign req_addr  = qa[issue_idx[3:0]];
  assign req_len   = ql[issue_idx[3:0]];
  assign dat_in    = src;

  burst_dma_wr u_burst_dma_wr (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .dat_in(dat_in), .dat_pop(dat_pop),
    .done(done), .cyc_n(cyc_n), .mst_rdy_n(mst_rdy_n), .tgt_rdy_n(tgt_rdy_n),
    .tgt_claim_n(tgt_claim_n), .tgt_stop_n(tgt_stop_n), .ad_oe(ad_oe),
    .bus_ad(bus_ad), .bus_cmd_n(bus_cmd_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) src <= 32'hA000_0000;
    else if (dat_pop) src <= src + 32'd1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // target model and bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (hs_pend) begin issue_idx = issue_idx + 5'd1; hs_pend = 0; end
      if (!exp_loaded && head < n_q) begin
        exp_addr = qa[head[3:0]];
        exp_left = int'(ql[head[3:0]]) + 1;
        exp_loaded = 1;
      end
      tgt_claim_n = mst_rdy_n;
      tgt_stop_n  = 1'b1;
      tgt_rdy_n   = mst_rdy_n;
      if (!mst_rdy_n && stall_mode) begin
        stall_tog = !stall_tog;
        if (stall_tog) tgt_rdy_n = 1'b1;
      end
      if (!mst_rdy_n && disc_armed && nxfer == disc_at) begin
        tgt_stop_n = 1'b0;
        if (!disc_data) tgt_rdy_n = 1'b1;
        disc_armed = 0;
      end
      #1;
      if (!gnt) chk(req_ready == 1'b0, "R9 ready without grant", {31'b0, req_ready}, 0);
      if (!cyc_n && mst_rdy_n) begin
        chk(bus_ad == exp_addr, "R1 address", bus_ad, exp_addr);
        chk(bus_cmd_n == 4'b0111, "R1 command", {28'b0, bus_cmd_n}, 32'h7);
        chk(ad_oe == 1'b1, "R1 drive enable", {31'b0, ad_oe}, 1);
        if (nap < 32) gap_log[nap] = idle_run;
        nap++;
        idle_run = 0;
      end else if (!mst_rdy_n) begin
        chk(bus_cmd_n == 4'b0000, "R2 byte enables", {28'b0, bus_cmd_n}, 0);
        chk(cyc_n == (exp_left == 1), "R4 cycle end marker", {31'b0, cyc_n}, {31'b0, exp_left == 1});
        if (!tgt_rdy_n) begin
          chk(bus_ad == exp_data, "R2 data word", bus_ad, exp_data);
          chk(dat_pop == 1'b1, "R5 pop on move", {31'b0, dat_pop}, 1);
          chk(done == (exp_left == 1), "R6 done", {31'b0, done}, {31'b0, exp_left == 1});
          exp_data = exp_data + 1;
          exp_addr = exp_addr + 4;
          exp_left--;
          nxfer++;
          if (exp_left == 0) begin head = head + 5'd1; exp_loaded = 0; end
        end else begin
          chk(dat_pop == 1'b0, "R5 no pop on wait", {31'b0, dat_pop}, 0);
          chk(done == 1'b0, "R6 no done on wait", {31'b0, done}, 0);
        end
      end else begin
        chk(ad_oe == 1'b0, "R8 R10 idle drive", {31'b0, ad_oe}, 0);
        idle_run++;
      end
      hs_pend = req_valid && req_ready;
    end
  end

  task automatic new_scenario();
    @(posedge clk); #1;
    n_q = 0; issue_idx = 0; head = 0; exp_loaded = 0;
    nap = 0; nxfer = 0; idle_run = 0;
    stall_mode = 0; disc_armed = 0; disc_data = 0;
  endtask

  task automatic push(input logic [31:0] a, input logic [3:0] l);
    qa[n_q[3:0]] = a; ql[n_q[3:0]] = l; n_q = n_q + 5'd1;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (head < n_q && k < 2000) begin @(posedge clk); k++; end
    chk(k < 2000, tag, k, 0);
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(cyc_n && mst_rdy_n, "R10 bus idle in reset", {30'b0, cyc_n, mst_rdy_n}, 3);
    chk(!ad_oe && !dat_pop && !done, "R10 quiet in reset", {29'b0, ad_oe, dat_pop, done}, 0);
  endtask

  task automatic t_full();
    new_scenario(); gnt = 1;
    push(32'h0000_1000, 4'd15);
    wait_done("R3 full burst completes");
    chk(nap == 1, "R3 one address phase", nap, 1);
    chk(nxfer == 16, "R3 sixteen words", nxfer, 16);
  endtask

  task automatic t_chain();
    new_scenario(); gnt = 1;
    push(32'h0000_2000, 4'd2);
    push(32'h0000_3000, 4'd0);
    push(32'h0000_4000, 4'd4);
    wait_done("R7 chain completes");
    chk(nap == 3, "R7 three address phases", nap, 3);
    chk(gap_log[1] == 0, "R7 no gap before second", gap_log[1], 0);
    chk(gap_log[2] == 0, "R7 no gap before third", gap_log[2], 0);
    chk(nxfer == 9, "R3 chain word count", nxfer, 9);
  endtask

  task automatic t_stall();
    new_scenario(); gnt = 1; stall_mode = 1;
    push(32'h0000_0100, 4'd7);
    wait_done("R2 stalled burst completes");
    chk(nap == 1, "R2 one address phase with stalls", nap, 1);
    chk(nxfer == 8, "R2 eight words with stalls", nxfer, 8);
  endtask

  task automatic t_disc(input bit with_data, input int at);
    new_scenario(); gnt = 1;
    disc_armed = 1; disc_data = with_data; disc_at = at;
    push(32'h0000_5000, 4'd15);
    wait_done("R8 resumed burst completes");
    chk(nap == 2, "R8 resume address phase", nap, 2);
    chk(gap_log[1] == 2, "R8 two idle clocks", gap_log[1], 2);
    chk(nxfer == 16, "R8 no word lost", nxfer, 16);
  endtask

  task automatic t_grant();
    new_scenario(); gnt = 0;
    push(32'h0000_6000, 4'd2);
    push(32'h0000_7000, 4'd1);
    repeat (6) @(posedge clk);
    #1;
    chk(nap == 0, "R9 no start without grant", nap, 0);
    chk(cyc_n == 1'b1, "R9 bus idle without grant", {31'b0, cyc_n}, 1);
    gnt = 1;
    while (mst_rdy_n) begin @(posedge clk); #1; end
    gnt = 0;
    while (head < 1) begin @(posedge clk); #1; end
    repeat (8) @(posedge clk);
    #1;
    chk(nap == 1, "R9 stop at burst boundary", nap, 1);
    chk(issue_idx == 5'd1, "R9 next request left pending", {27'b0, issue_idx}, 1);
    gnt = 1;
    wait_done("R9 pending request completes");
    chk(nap == 2, "R9 pending request started", nap, 2);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    @(posedge clk); #1;
    rst_n = 1;
    t_full();
    t_chain();
    t_stall();
    t_disc(1'b1, 5);
    t_disc(1'b0, 3);
    t_grant();
    finish_run();
  end
endmodule